// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable model of a word-organised synchronous SRAM of the kind placed beside a processor as a secondary cache. Address, control and write data are captured on the rising clock edge. Read data then passes through an output register, so a read sampled on edge k is presented on the ports after edge k+1. One presented address can produce four data beats. An internal two-bit counter walks the low address bits in linear or interleaved order while the upper bits stay fixed. The counter keeps wrapping inside the four-word group for as long as advance is held.

Writes are either global, writing all four byte lanes, or per-lane under a byte-write enable. A chip select that is inactive during an address strobe deselects the part. This ends the burst and stops output data in the next pipelined cycle. A sleep input blocks every new access while it is high.

The parameter `ADDR_W` defaults to 10 (1024 words) so that the model stays small when elaborated. Set to 16, it gives the full 65,536-word array. The output-enable drivers are modelled as the `rd_valid` flag.

Top module: `burst_sram`

## Requirements
- R1: After reset `rd_valid` is 0 and stays 0 until a read is issued.
- R2: A read issued on edge k (`strobe_n`=0, `sel_n`=0, `gw_n`=1, `bwe_n`=1, `sleep`=0) drives `rd_valid`=1 and `rd_data`=word at the issued address after edge k+1. A cycle that issues no read gives `rd_valid`=0 one edge later.
- R3: While a burst is active and `strobe_n`=1, `adv_n`=0 issues the next burst beat on each edge, with the same write controls as a first cycle. `adv_n`=1 issues nothing and keeps the burst position.
- R4: With `lin_mode`=1 the beat-i address has low two bits (a0 + i) mod 4, where a0 is the low two bits of the strobed address.
- R5: With `lin_mode`=0 the beat-i address has low two bits a0 XOR (i mod 4). In both orders the upper `ADDR_W`-2 bits never change, and the order keeps wrapping after the fourth beat.
- R6: `gw_n`=0 writes all 32 bits of the issued address.
- R7: With `gw_n`=1 and `bwe_n`=0, lane n (`wr_data[8n+7:8n]`) is written only when `bw_n[n]`=0. The other lanes keep their contents.
- R8: With `gw_n`=1 and `bwe_n`=1 the cycle is a read whatever `bw_n` holds, and memory is unchanged.
- R9: `strobe_n`=0 with `sel_n`=0 loads a new start address and restarts the beat count, also in the middle of a burst.
- R10: `strobe_n`=0 with `sel_n`=1 issues no access, gives `rd_valid`=0 after the following edge, and ends the burst, so a later `adv_n`=0 issues nothing.
- R11: While `sleep`=1 no access is issued: writes are ignored, reads give no `rd_valid`, and the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Blocks all accesses while high |
| strobe_n | input | 1 | Address strobe, active low |
| sel_n | input | 1 | Chip select, active low, sampled with the strobe |
| adv_n | input | 1 | Burst advance, active low |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | Start address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-lane write strobes, active low |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data present |

## Verification
The hardest situations to reach are those where the burst state and the pipeline overlap. Examples are a strobe landing in the middle of a burst, a deselect followed by an advance that must be ignored, and a sleep cycle arriving while a burst is active. The bench drives back-to-back cycles with no idle gap. It keeps its own model of the burst position and the memory contents, and queues one expected output per cycle. Every pipelined beat is therefore compared in the cycle it appears, including the wrap past the fourth beat in both orders.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              strobe_n,
  input  logic              sel_n,
  input  logic              adv_n,
  input  logic              lin_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              active;

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_valid, acc_write;
  logic [LANES-1:0]  acc_be;
  logic [DATA_W-1:0] acc_wd;

  wire load   = !sleep && !strobe_n && !sel_n;
  wire desel  = !sleep && !strobe_n && sel_n;
  wire step   = !sleep && strobe_n && active && !adv_n;
  wire issue  = load || step;

  wire [1:0] cnt_nx = cnt + 2'd1;
  wire [1:0] low_nx = lin_mode ? (base[1:0] + cnt_nx) : (base[1:0] ^ cnt_nx);
  wire [ADDR_W-1:0] beat_addr = {base[ADDR_W-1:2], low_nx};
  wire [ADDR_W-1:0] issue_addr = load ? addr : beat_addr;

  wire is_wr = !gw_n || !bwe_n;
  wire [LANES-1:0] lanes = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (sleep || desel) begin
      active <= 1'b0;
    end else if (load) begin
      base   <= addr;
      cnt    <= '0;
      active <= 1'b1;
    end else if (step) begin
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
      acc_wd    <= '0;
    end else begin
      acc_valid <= issue;
      acc_write <= is_wr;
      acc_addr  <= issue_addr;
      acc_be    <= lanes;
      acc_wd    <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_valid && acc_write)
      for (int n = 0; n < LANES; n++)
        if (acc_be[n]) mem[acc_addr][8*n +: 8] <= acc_wd[8*n +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= mem[acc_addr];
    end
  end

  // R2
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!sleep && (!strobe_n ? !sel_n : !adv_n) && gw_n && bwe_n, 2));

  // R10
  desel_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> ##1 !rd_valid);

  // R11
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ##1 !rd_valid);

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> acc_addr[ADDR_W-1:2] == $past(base[ADDR_W-1:2]));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + 2'd1);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == 2'd0) && active && acc_addr == $past(addr));

endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic sleep = 0, strobe_n = 1, sel_n = 0, adv_n = 1, lin_mode = 1;
  logic [AW-1:0] addr = '0;
  logic gw_n = 1, bwe_n = 1;
  logic [3:0] bw_n = 4'hF;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rd_valid;

  burst_sram #(.ADDR_W(AW)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic v; logic [31:0] d; string tag; } item_t;
  item_t q[$];
  int tests = 0, fails = 0;
  logic [31:0] shadow [int];
  logic [AW-1:0] m_base; logic [1:0] m_cnt; logic m_act = 0; logic m_lin;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit st_n, bit sl_n, bit av_n, bit lin, logic [AW-1:0] a,
                       bit g_n, bit be_n, logic [3:0] b_n, logic [31:0] wd,
                       bit slp, string tag);
    item_t it;
    bit iss = 0;
    logic [AW-1:0] ia;
    @(negedge clk);
    strobe_n = st_n; sel_n = sl_n; adv_n = av_n; lin_mode = lin; addr = a;
    gw_n = g_n; bwe_n = be_n; bw_n = b_n; wr_data = wd; sleep = slp;
    if (slp) m_act = 0;
    else if (!st_n && sl_n) m_act = 0;
    else if (!st_n) begin
      m_base = a; m_cnt = 0; m_act = 1; iss = 1; ia = a;
    end else if (m_act && !av_n) begin
      m_cnt = m_cnt + 1; iss = 1;
      ia = {m_base[AW-1:2], lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
    end
    it.v = 0; it.d = 0; it.tag = tag;
    if (iss) begin
      if (!g_n || !be_n) begin
        logic [31:0] w;
        w = shadow.exists(int'(ia)) ? shadow[int'(ia)] : 32'h0;
        for (int n = 0; n < 4; n++)
          if (!g_n || !b_n[n]) w[8*n +: 8] = wd[8*n +: 8];
        shadow[int'(ia)] = w;
      end else begin
        it.v = 1; it.d = shadow[int'(ia)];
      end
    end
    q.push_back(it);
  endtask

  task automatic idle(string tag); drive(1,0,1,1,0,1,1,4'hF,0,0,tag); endtask
  task automatic rd(logic [AW-1:0] a, bit lin, string tag); drive(0,0,1,lin,a,1,1,4'hF,0,0,tag); endtask
  task automatic nx(bit lin, string tag); drive(1,0,0,lin,0,1,1,4'hF,0,0,tag); endtask
  task automatic gwr(logic [AW-1:0] a, logic [31:0] d, string tag); drive(0,0,1,1,a,0,1,4'hF,d,0,tag); endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #5;
      if (rst_n && q.size() >= 2) begin
        item_t it;
        it = q.pop_front();
        chk(rd_valid == it.v, {it.tag, " valid"}, {31'b0, rd_valid}, {31'b0, it.v});
        if (it.v) chk(rd_data == it.d, {it.tag, " data"}, rd_data, it.d);
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_valid == 0, "R1 reset", {31'b0, rd_valid}, 32'h0);
    idle("R1 idle");
    for (int i = 0; i < 8; i++) gwr(AW'(8'h40 + i), 32'hA000_0000 + 32'(i) * 32'h0101_0101, "R6 global write");
    rd(AW'(8'h41), 1, "R2 single read");
    idle("R2 idle");
    rd(AW'(8'h42), 1, "R4 linear b0");
    for (int i = 0; i < 4; i++) nx(1, "R4 linear beat/wrap");
    rd(AW'(8'h46), 0, "R5 interleave b0");
    for (int i = 0; i < 3; i++) nx(0, "R5 interleave beat");
    rd(AW'(8'h45), 0, "R5 interleave a0=1");
    for (int i = 0; i < 4; i++) nx(0, "R5 interleave a0=1 wrap");
    rd(AW'(8'h40), 1, "R3 start");
    idle("R3 hold no beat");
    nx(1, "R3 resume");
    nx(1, "R3 resume2");
    rd(AW'(8'h44), 1, "R9 first");
    nx(1, "R9 beat");
    rd(AW'(8'h47), 0, "R9 restart");
    nx(0, "R9 restarted beat");
    drive(0,0,1,1,AW'(8'h41),1,0,4'b1010,32'h1122_3344,0,"R7 byte write");
    rd(AW'(8'h41), 1, "R7 readback");
    drive(0,0,1,1,AW'(8'h42),1,1,4'b0000,32'hFFFF_FFFF,0,"R8 bw ignored read");
    rd(AW'(8'h42), 1, "R8 unchanged");
    rd(AW'(8'h43), 1, "R10 burst");
    drive(0,1,1,1,AW'(8'h40),1,1,4'hF,0,0,"R10 deselect");
    nx(1, "R10 adv after deselect");
    nx(1, "R10 adv after deselect 2");
    rd(AW'(8'h40), 1, "R11 burst");
    drive(0,0,1,1,AW'(8'h44),0,1,4'hF,32'hDEAD_BEEF,1,"R11 sleep write");
    drive(0,0,1,1,AW'(8'h44),1,1,4'hF,0,1,"R11 sleep read");
    nx(1, "R11 adv after sleep");
    rd(AW'(8'h44), 1, "R11 unchanged");
    drive(0,0,1,1,AW'(8'h4A),0,1,4'hF,32'h0BAD_0000,0,"R3 burst write b0");
    drive(1,0,0,1,0,0,1,4'hF,32'h0BAD_0001,0,"R3 burst write b1");
    drive(1,0,0,1,0,0,1,4'hF,32'h0BAD_0002,0,"R3 burst write b2");
    drive(1,0,0,1,0,0,1,4'hF,32'h0BAD_0003,0,"R3 burst write b3");
    for (int i = 0; i < 4; i++) rd(AW'(8'h48 + i), 1, "R4 burst write readback");
    repeat (3) idle("drain");
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule